// File: doc/BRIEF.md
# Interrupt Cause Register with Coalescing

This block collects hardware event strobes into a 32-bit sticky cause register and drives one level-sensitive interrupt line toward the host. The host reads and writes four registers through a simple synchronous port: the cause register, an enable mask, an 8-bit coalescing delay and an 8-bit periodic interval. A cause bit stays set until the host writes a 1 to its position. The line asserts once an enabled cause has been pending for the programmed coalescing delay.

Both timers count units of `UNIT_TICKS` pulses of the microsecond tick input, which is 32 µs by default. The coalescing delay resets to 0x40 (2048 µs) and can be set up to 0xFF. A value of zero removes the delay. A nonzero periodic interval raises the periodic-receive cause (bit 28) once per interval. A value of 0xFF gives roughly 8 ms, and zero stops it. A dedicated high-priority receive strobe sets the receive cause (bit 31). When that bit is enabled, the strobe forces the line high on the next cycle without waiting for the delay.

Top module: `intr_cause_ctrl`

## Requirements
- R1: After reset, cause reads 0, mask reads 0, the coalescing register reads 0x40, the periodic register reads 0 and `irqOut` is low.
- R2: A 1 on bit i of `evtSet` in one cycle sets cause bit i at the next clock edge. The bit then stays set, including across host writes of 0 to that position.
- R3: A host write to the cause register (address 0) clears exactly the bits written as 1 and leaves all other bits unchanged.
- R4: If an event strobe and a host clear hit the same cause bit in the same cycle, the bit ends up set.
- R5: `irqOut` is low whenever (cause & mask) is zero. Disabled cause bits never raise it.
- R6: With the coalescing register at 0, `irqOut` is high in the cycle after an enabled cause bit becomes set.
- R7: With the coalescing register at N>0, the delay starts when an enabled cause first becomes pending from an idle state. The delay advances only on cycles where `usTick` is high. `irqOut` rises on the cycle after N×UNIT_TICKS tick cycles have been counted. When `usTick` is high on every cycle, that is 1+N×UNIT_TICKS clock edges after the event edge.
- R8: When the host clears every enabled pending bit, `irqOut` drops at once. The next event waits the full coalescing delay again.
- R9: A `hiPrioRx` strobe sets cause bit 31. If mask bit 31 is set, `irqOut` is high in the following cycle whatever the coalescing value is. If mask bit 31 is clear, `irqOut` stays low.
- R10: With the periodic register at P>0, cause bit 28 is set every P×UNIT_TICKS tick cycles. The first setting comes within UNIT_TICKS+2 edges of a write of 1. With P=0, bit 28 is never set by the block.
- R11: The register map is: address 0 cause (write-1-to-clear), address 1 mask (32 bits), address 2 coalescing value in bits [7:0], address 3 periodic value in bits [7:0]. Unused upper bits of addresses 2 and 3 read 0, and the read data is combinational from `regAddr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for the selected register |
| evtSet | input | 32 | Per-bit event strobes that set cause bits |
| hiPrioRx | input | 1 | High-priority receive strobe (sets bit 31 and bypasses the delay) |
| usTick | input | 1 | One pulse per microsecond |
| irqOut | output | 1 | Level interrupt to the host |

## Verification
On every cycle the assertions check four things. A cause bit never falls without a host write to the cause register, and a strobed bit is always set on the next edge. An enabled high-priority strobe is always followed by a high line. The delay state drops when nothing enabled is pending, and the periodic strobe stays silent while the interval is zero. The exact coalescing latency needs the directed scenarios: the edge count to assertion, the stall while `usTick` is low, and the reload after a full clear. The same holds for the periodic cadence and the register read-back masking.

// File: rtl/intr_cause_pkg.sv
package intr_cause_pkg;
  localparam int CAUSE_W      = 32;
  localparam int CFG_W        = 8;
  localparam int ADDR_W       = 2;
  localparam int HIPRIO_BIT   = 31;
  localparam int PERIODIC_BIT = 28;

  typedef enum logic [ADDR_W-1:0] {
    REG_CAUSE  = 2'd0,
    REG_MASK   = 2'd1,
    REG_COAL   = 2'd2,
    REG_PERIOD = 2'd3
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic periodicSet;
  } ctrlStrobe_t;

  // register state seen by the control
  typedef struct packed {
    logic             pending;
    logic             hiMaskOn;
    logic [CFG_W-1:0] coalVal;
    logic [CFG_W-1:0] periodVal;
  } regView_t;
endpackage

// File: rtl/intr_cause_regs.sv
module intr_cause_regs
  import intr_cause_pkg::*;
#(
  parameter logic [CFG_W-1:0] COAL_RESET = 8'h40
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [CAUSE_W-1:0]  regWrData,
  output logic [CAUSE_W-1:0]  regRdData,
  input  logic [CAUSE_W-1:0]  evtSet,
  input  logic                hiPrio,
  input  ctrlStrobe_t         strobes,
  output regView_t            view
);
  localparam int PAD_W = CAUSE_W - CFG_W;

  logic [CAUSE_W-1:0] cause;
  logic [CAUSE_W-1:0] mask;
  logic [CFG_W-1:0]   coalVal;
  logic [CFG_W-1:0]   periodVal;
  logic [CAUSE_W-1:0] setBits;
  logic [CAUSE_W-1:0] clrBits;
  logic               wrCause;

  assign wrCause = regWrEn && (regAddr == REG_CAUSE);

  always_comb begin
    setBits = evtSet;
    setBits[HIPRIO_BIT]   = setBits[HIPRIO_BIT] | hiPrio;
    setBits[PERIODIC_BIT] = setBits[PERIODIC_BIT] | strobes.periodicSet;
    clrBits = wrCause ? regWrData : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cause     <= '0;
      mask      <= '0;
      coalVal   <= COAL_RESET;
      periodVal <= '0;
    end else begin
      // set takes priority over a same-cycle clear
      cause <= (cause & ~clrBits) | setBits;
      if (regWrEn && regAddr == REG_MASK)   mask      <= regWrData;
      if (regWrEn && regAddr == REG_COAL)   coalVal   <= regWrData[CFG_W-1:0];
      if (regWrEn && regAddr == REG_PERIOD) periodVal <= regWrData[CFG_W-1:0];
    end
  end

  always_comb begin
    case (regAddr)
      REG_CAUSE:  regRdData = cause;
      REG_MASK:   regRdData = mask;
      REG_COAL:   regRdData = {{PAD_W{1'b0}}, coalVal};
      default:    regRdData = {{PAD_W{1'b0}}, periodVal};
    endcase
  end

  assign view.pending   = |(cause & mask);
  assign view.hiMaskOn  = mask[HIPRIO_BIT];
  assign view.coalVal   = coalVal;
  assign view.periodVal = periodVal;

  // R2 R3
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == REG_CAUSE) |=> ((cause & $past(cause)) == $past(cause)));

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|evtSet) |=> ((cause & $past(evtSet)) == $past(evtSet)));
endmodule

// File: rtl/intr_coal_ctrl.sv
module intr_coal_ctrl
  import intr_cause_pkg::*;
#(
  parameter int UNIT_TICKS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        usTick,
  input  logic        hiPrio,
  input  regView_t    view,
  output ctrlStrobe_t strobes,
  output logic        irqOut
);
  localparam int SUB_W = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(UNIT_TICKS - 1);

  logic             running;
  logic             fired;
  logic [SUB_W-1:0] coalSub;
  logic [CFG_W-1:0] coalLeft;
  logic [SUB_W-1:0] perSub;
  logic [CFG_W-1:0] perLeft;
  logic             hiBypass;

  assign hiBypass = hiPrio && view.hiMaskOn;

  // coalescing delay
  always_ff @(posedge clk) begin
    if (!rstN) begin
      running  <= 1'b0;
      fired    <= 1'b0;
      coalSub  <= '0;
      coalLeft <= '0;
    end else if (hiBypass) begin
      running <= 1'b0;
      fired   <= 1'b1;
    end else if (!view.pending) begin
      running <= 1'b0;
      fired   <= 1'b0;
    end else if (!running && !fired && view.coalVal != '0) begin
      running  <= 1'b1;
      coalLeft <= view.coalVal;
      coalSub  <= '0;
    end else if (running && usTick) begin
      if (coalSub == SUB_LAST) begin
        coalSub <= '0;
        if (coalLeft == CFG_W'(1)) begin
          running <= 1'b0;
          fired   <= 1'b1;
        end else begin
          coalLeft <= coalLeft - 1'b1;
        end
      end else begin
        coalSub <= coalSub + 1'b1;
      end
    end
  end

  // periodic cause generator
  always_ff @(posedge clk) begin
    if (!rstN) begin
      perSub              <= '0;
      perLeft             <= '0;
      strobes.periodicSet <= 1'b0;
    end else begin
      strobes.periodicSet <= 1'b0;
      if (view.periodVal == '0) begin
        perSub  <= '0;
        perLeft <= '0;
      end else if (perLeft == '0) begin
        perSub  <= '0;
        perLeft <= view.periodVal;
      end else if (usTick) begin
        if (perSub == SUB_LAST) begin
          perSub <= '0;
          if (perLeft == CFG_W'(1)) begin
            strobes.periodicSet <= 1'b1;
            perLeft             <= view.periodVal;
          end else begin
            perLeft <= perLeft - 1'b1;
          end
        end else begin
          perSub <= perSub + 1'b1;
        end
      end
    end
  end

  assign irqOut = view.pending && (fired || view.coalVal == '0);

  // R9
  bypass_fast_chk: assert property (@(posedge clk) disable iff (!rstN)
    hiBypass |=> irqOut);

  // R8
  idle_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!view.pending && !hiPrio) |=> (!fired && !running));

  // R7
  no_early_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(fired) && !$past(hiBypass)) |-> $past(running));

  // R10
  period_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (view.periodVal == '0) |=> !strobes.periodicSet);
endmodule

// File: rtl/intr_cause_ctrl.sv
module intr_cause_ctrl
  import intr_cause_pkg::*;
#(
  parameter int               UNIT_TICKS = 32,
  parameter logic [CFG_W-1:0] COAL_RESET = 8'h40
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [CAUSE_W-1:0] regWrData,
  output logic [CAUSE_W-1:0] regRdData,
  input  logic [CAUSE_W-1:0] evtSet,
  input  logic               hiPrioRx,
  input  logic               usTick,
  output logic               irqOut
);
  ctrlStrobe_t strobes;
  regView_t    view;

  intr_cause_regs #(.COAL_RESET(COAL_RESET)) dpath (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .evtSet(evtSet),
    .hiPrio(hiPrioRx), .strobes(strobes), .view(view)
  );

  intr_coal_ctrl #(.UNIT_TICKS(UNIT_TICKS)) ctrl (
    .clk(clk), .rstN(rstN), .usTick(usTick), .hiPrio(hiPrioRx),
    .view(view), .strobes(strobes), .irqOut(irqOut)
  );

  // R5
  irq_needs_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> view.pending);
endmodule

// File: tb/intr_cause_ctrl_test.sv
module intr_cause_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int UNIT = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [31:0] evtSet = '0;
  logic        hiPrioRx = 1'b0;
  logic        usTick = 1'b1;
  logic        irqOut;

  int checks = 0;
  int errors = 0;

  intr_cause_ctrl #(.UNIT_TICKS(UNIT)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .evtSet(evtSet),
    .hiPrioRx(hiPrioRx), .usTick(usTick), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic pulseEvt(input logic [31:0] bits);
    @(negedge clk);
    evtSet = bits;
    @(negedge clk);
    evtSet = '0;
  endtask

  task automatic pulseHi();
    @(negedge clk);
    hiPrioRx = 1'b1;
    @(negedge clk);
    hiPrioRx = 1'b0;
  endtask

  task automatic clearAll();
    regWrite(2'd0, 32'hFFFF_FFFF);
    regWrite(2'd1, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    readReg(2'd0, d); check("R1 cause", d, 32'h0);
    readReg(2'd1, d); check("R1 mask", d, 32'h0);
    readReg(2'd2, d); check("R1 coal", d, 32'h40);
    readReg(2'd3, d); check("R1 period", d, 32'h0);
    check("R1 irq", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_set_clear();
    logic [31:0] d;
    pulseEvt(32'h0000_0008);
    readReg(2'd0, d); check("R2 set bit3", d, 32'h8);
    check("R5 masked irq", {31'b0, irqOut}, 32'h0);
    regWrite(2'd0, 32'h0);
    readReg(2'd0, d); check("R2 write0 keeps", d, 32'h8);
    regWrite(2'd0, 32'h0000_0009);
    readReg(2'd0, d); check("R3 clear", d, 32'h0);
    pulseEvt(32'h0000_0041);
    regWrite(2'd0, 32'h0000_0001);
    readReg(2'd0, d); check("R3 partial clear", d, 32'h40);
    regWrite(2'd0, 32'h40);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    pulseEvt(32'h80);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 2'd0; regWrData = 32'h80; evtSet = 32'h80;
    @(negedge clk);
    regWrEn = 1'b0; evtSet = '0;
    readReg(2'd0, d); check("R4 set wins", d, 32'h80);
    regWrite(2'd0, 32'h80);
  endtask

  task automatic t_immediate();
    regWrite(2'd2, 32'h0);
    regWrite(2'd1, 32'h2);
    pulseEvt(32'h2);
    check("R6 immediate irq", {31'b0, irqOut}, 32'h1);
    regWrite(2'd1, 32'h0);
    check("R5 mask off", {31'b0, irqOut}, 32'h0);
    regWrite(2'd0, 32'h2);
  endtask

  task automatic t_coalesce();
    regWrite(2'd2, 32'h2);
    regWrite(2'd1, 32'h0200_0000);
    pulseEvt(32'h0200_0000);
    repeat (2*UNIT) @(negedge clk);
    check("R7 before expiry", {31'b0, irqOut}, 32'h0);
    @(negedge clk);
    check("R7 at expiry", {31'b0, irqOut}, 32'h1);
    regWrite(2'd0, 32'h0200_0000);
    check("R8 drop on clear", {31'b0, irqOut}, 32'h0);
    repeat (3) @(negedge clk);
    pulseEvt(32'h0200_0000);
    repeat (2*UNIT) @(negedge clk);
    check("R8 reload wait", {31'b0, irqOut}, 32'h0);
    @(negedge clk);
    check("R8 reload fire", {31'b0, irqOut}, 32'h1);
    regWrite(2'd0, 32'h0200_0000);
    repeat (3) @(negedge clk);
    usTick = 1'b0;
    pulseEvt(32'h0200_0000);
    repeat (200) @(negedge clk);
    check("R7 tick stall", {31'b0, irqOut}, 32'h0);
    usTick = 1'b1;
    repeat (2*UNIT + 2) @(negedge clk);
    check("R7 tick resume", {31'b0, irqOut}, 32'h1);
    clearAll();
  endtask

  task automatic t_bypass();
    logic [31:0] d;
    regWrite(2'd2, 32'hFF);
    regWrite(2'd1, 32'h8800_0000);
    pulseEvt(32'h0800_0000);
    repeat (5) @(negedge clk);
    check("R7 long delay", {31'b0, irqOut}, 32'h0);
    pulseHi();
    check("R9 bypass irq", {31'b0, irqOut}, 32'h1);
    readReg(2'd0, d); check("R9 bit31 set", d, 32'h8800_0000);
    clearAll();
    regWrite(2'd1, 32'h0800_0000);
    pulseHi();
    repeat (3) @(negedge clk);
    check("R9 masked no irq", {31'b0, irqOut}, 32'h0);
    readReg(2'd0, d); check("R9 masked sets cause", d, 32'h8000_0000);
    clearAll();
  endtask

  task automatic t_periodic();
    logic [31:0] d;
    regWrite(2'd2, 32'hFFFF_FF00);
    readReg(2'd2, d); check("R11 coal width", d, 32'h0);
    regWrite(2'd1, 32'h1000_0000);
    regWrite(2'd3, 32'hFFFF_FF01);
    readReg(2'd3, d); check("R11 period width", d, 32'h1);
    repeat (UNIT - 1) @(negedge clk);
    readReg(2'd0, d); check("R10 not yet", d, 32'h0);
    repeat (3) @(negedge clk);
    readReg(2'd0, d); check("R10 periodic set", d, 32'h1000_0000);
    check("R10 periodic irq", {31'b0, irqOut}, 32'h1);
    regWrite(2'd0, 32'h1000_0000);
    repeat (UNIT + 2) @(negedge clk);
    readReg(2'd0, d); check("R10 repeats", d, 32'h1000_0000);
    regWrite(2'd3, 32'h0);
    repeat (3) @(negedge clk);
    regWrite(2'd0, 32'h1000_0000);
    repeat (3*UNIT) @(negedge clk);
    readReg(2'd0, d); check("R10 disabled", d, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_clear();
    t_set_wins();
    t_immediate();
    t_coalesce();
    t_bypass();
    t_periodic();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule